// File: doc/BRIEF.md
# Duplicated-Transfer Receive Selector

This block sits on the receive side of a replicated-memory ring link, after the link checker. In protected mode the sender puts every logical transfer on the link twice, one copy straight after the other. Each received copy carries an error flag from the checker and a sequence bit that flips from one logical transfer to the next. The block pairs the two copies of each transfer. It forwards the first copy if that copy is clean, or the second copy if only the first is corrupt. When both copies are corrupt it delivers nothing, so the transfer goes no further.

With protected mode off, every received transfer stands alone. A clean transfer goes straight to the output and an errored one is dropped. In both modes the block keeps three saturating counters: pairs with exactly one bad copy, transfers lost outright, and sequence (pairing) errors. It can also raise a one-cycle error event for every errored copy, but only while error events are armed.

Top module: `dup_rx_select`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `out_valid` and `err_event` are 0 and all three counters read 0.
- R2: In protected mode, when a pair completes and the first copy has `in_err`=0, `out_valid` is 1 for one cycle on the cycle after the second copy is accepted, and `out_data` equals the first copy's data. The second copy's data is discarded.
- R3: In protected mode, when the first copy of a pair has `in_err`=1 and the second has `in_err`=0, the output carries the second copy's data. `fix_count` increases by 1 for any pair with exactly one errored copy, whichever copy it is.
- R4: In protected mode, when both copies of a pair have `in_err`=1, `out_valid` stays 0 and `lost_count` increases by 1.
- R5: In protected mode, a copy that arrives while no first copy is held becomes the held first copy. If its `in_seq` differs from the expected bit, `frame_count` increases by 1. The expected bit is 0 after reset and is the inverse of `in_seq` of the last completed pair. If the copy after a held first copy has a different `in_seq`, `frame_count` increases by 1, the held copy is dropped without output, and the new copy becomes the held first copy.
- R6: With `dual_en`=0, a transfer with `in_err`=0 appears on `out_data` with `out_valid`=1 on the next cycle. A transfer with `in_err`=1 produces no output and increases `lost_count` by 1.
- R7: `err_event` is 1 for exactly the cycle after an accepted transfer with `in_err`=1 while `irq_arm`=1. When `irq_arm`=0 it stays 0. Sequence errors do not raise it.
- R8: Each counter is `CNT_W` bits wide and stops at 2^`CNT_W`-1. It never wraps and never moves by more than 1 per cycle.
- R9: In protected mode, `out_valid` is never high on two consecutive cycles, and it is high only on the cycle after an accepted copy.
- R10: A cycle with `dual_en`=0 discards any held first copy and sets the expected sequence bit back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_en | input | 1 | 1 = protected mode (two copies per transfer) |
| irq_arm | input | 1 | Allows error events |
| in_valid | input | 1 | A received copy is present |
| in_data | input | DATA_W | Received payload |
| in_err | input | 1 | Link checker flagged this copy |
| in_seq | input | 1 | Per-transfer sequence bit |
| out_valid | output | 1 | Selected transfer present |
| out_data | output | DATA_W | Selected payload |
| err_event | output | 1 | One-cycle error event |
| fix_count | output | CNT_W | Pairs with exactly one errored copy |
| lost_count | output | CNT_W | Transfers not delivered because of errors |
| frame_count | output | CNT_W | Sequence/pairing errors |

## Verification
The assertions assume that `dual_en` and `irq_arm` are not undefined and that `in_valid` is a clean level every cycle after reset. The pass-through checks also assume that `in_data` is defined whenever `in_valid` is high. The stimulus changes every input at the falling edge, keeps `in_valid` low whenever the mode is being switched, and always drives defined data alongside a valid copy, so each property only ever sees settled, meaningful values.

// File: rtl/dup_rx_pkg.sv
package dup_rx_pkg;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_HELD = 2'd1,
        PICK_CUR  = 2'd2
    } pick_e;

    typedef struct packed {
        logic frame;
        logic both_bad;
        logic one_bad;
    } rx_events_t;

    localparam int NUM_CNT = 3;

    function automatic logic at_max(input logic [63:0] value, input int width);
        logic [63:0] limit;
        limit = (64'd1 << width) - 64'd1;
        return value == limit;
    endfunction

endpackage

// File: rtl/dup_pair_tracker.sv
module dup_pair_tracker
    import dup_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dual_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_err,
    input  logic              in_seq,
    output pick_e             pick,
    output logic [DATA_W-1:0] held_data,
    output rx_events_t        ev
);

    logic have_held;
    logic held_err;
    logic held_seq;
    logic exp_seq;

    always_comb begin
        pick = PICK_NONE;
        ev   = '0;
        if (in_valid) begin
            if (!dual_en) begin
                if (in_err) ev.both_bad = 1'b1;
                else        pick = PICK_CUR;
            end else if (!have_held) begin
                ev.frame = (in_seq != exp_seq);
            end else if (in_seq != held_seq) begin
                ev.frame = 1'b1;
            end else begin
                if (!held_err)     pick = PICK_HELD;
                else if (!in_err)  pick = PICK_CUR;
                ev.one_bad  = held_err ^ in_err;
                ev.both_bad = held_err & in_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dual_en) begin
            have_held <= 1'b0;
            exp_seq   <= 1'b0;
        end else if (in_valid) begin
            if (!have_held || (in_seq != held_seq)) begin
                have_held <= 1'b1;
            end else begin
                have_held <= 1'b0;
                exp_seq   <= ~in_seq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_data <= '0;
            held_err  <= 1'b0;
            held_seq  <= 1'b0;
        end else if (dual_en && in_valid && (!have_held || (in_seq != held_seq))) begin
            held_data <= in_data;
            held_err  <= in_err;
            held_seq  <= in_seq;
        end
    end

endmodule

// File: rtl/dup_sat_counter.sv
module dup_sat_counter
    import dup_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && !at_max(64'(count), W))
            count <= count + 1'b1;
    end

endmodule

// File: rtl/dup_rx_select.sv
module dup_rx_select
    import dup_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dual_en,
    input  logic              irq_arm,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_err,
    input  logic              in_seq,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              err_event,
    output logic [CNT_W-1:0]  fix_count,
    output logic [CNT_W-1:0]  lost_count,
    output logic [CNT_W-1:0]  frame_count
);

    pick_e             pick;
    logic [DATA_W-1:0] held_data;
    rx_events_t        ev;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_arr [NUM_CNT];

    dup_pair_tracker #(.DATA_W(DATA_W)) tracker (
        .clk       (clk),
        .rst       (rst),
        .dual_en   (dual_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_err    (in_err),
        .in_seq    (in_seq),
        .pick      (pick),
        .held_data (held_data),
        .ev        (ev)
    );

    assign inc_vec = {ev.frame, ev.both_bad, ev.one_bad};

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        dup_sat_counter #(.W(CNT_W)) ctr (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc_vec[i]),
            .count (cnt_arr[i])
        );
    end

    assign fix_count   = cnt_arr[0];
    assign lost_count  = cnt_arr[1];
    assign frame_count = cnt_arr[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            err_event <= 1'b0;
        end else begin
            out_valid <= (pick != PICK_NONE);
            if (pick == PICK_HELD)     out_data <= held_data;
            else if (pick == PICK_CUR) out_data <= in_data;
            err_event <= in_valid & in_err & irq_arm;
        end
    end

endmodule

// File: rtl/dup_rx_select_chk.sv
module dup_rx_select_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dual_en,
    input logic              irq_arm,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_err,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              err_event,
    input logic [CNT_W-1:0]  lost_count,
    input logic [CNT_W-1:0]  fix_count,
    input logic [CNT_W-1:0]  frame_count
);

    // R6
    pass_good_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dual_en && !in_err) |=> (out_valid && out_data == $past(in_data)));

    // R6
    pass_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dual_en && in_err) |=> !out_valid);

    // R7
    event_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_err && irq_arm) |=> err_event);

    // R7
    event_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_err && irq_arm) |=> !err_event);

    // R9
    out_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R9
    dual_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(dual_en) && $past(dual_en, 2)) |-> !$past(out_valid));

    // R8
    lost_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lost_count == $past(lost_count)) || (lost_count == $past(lost_count) + 1'b1));

    // R8
    fix_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fix_count == $past(fix_count)) || (fix_count == $past(fix_count) + 1'b1));

    // R8
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_count == $past(frame_count)) || (frame_count == $past(frame_count) + 1'b1));

endmodule

bind dup_rx_select dup_rx_select_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk (
    .clk         (clk),
    .rst         (rst),
    .dual_en     (dual_en),
    .irq_arm     (irq_arm),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_err      (in_err),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .err_event   (err_event),
    .lost_count  (lost_count),
    .fix_count   (fix_count),
    .frame_count (frame_count)
);

// File: tb/dup_rx_select_test.sv
module dup_rx_select_test;

    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dual_en = 1'b1;
    logic          irq_arm = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_err = 1'b0;
    logic          in_seq = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          err_event;
    logic [CW-1:0] fix_count, lost_count, frame_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dup_rx_select #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .dual_en(dual_en), .irq_arm(irq_arm),
        .in_valid(in_valid), .in_data(in_data), .in_err(in_err), .in_seq(in_seq),
        .out_valid(out_valid), .out_data(out_data), .err_event(err_event),
        .fix_count(fix_count), .lost_count(lost_count), .frame_count(frame_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one copy for one cycle; returns at the falling edge after it was taken.
    task automatic send(input logic [DW-1:0] d, input logic e, input logic s);
        in_valid = 1'b1; in_data = d; in_err = e; in_seq = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 err_event in reset", err_event, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 counters after reset", {fix_count, lost_count, frame_count}, 0);
    endtask

    task automatic t_first_good;
        send(16'hA001, 0, 0);
        check("R2 no output after first copy", out_valid, 0);
        send(16'h5FFE, 0, 0);
        check("R2 out_valid after pair", out_valid, 1);
        check("R2 first copy data", out_data, 16'hA001);
        idle(1);
        check("R9 single pulse", out_valid, 0);
        check("R3 fix_count unchanged", fix_count, 0);
    endtask

    task automatic t_first_bad;
        send(16'hC0C0, 1, 1);
        check("R7 event on errored copy", err_event, 1);
        check("R3 no output after first copy", out_valid, 0);
        send(16'hD00D, 0, 1);
        check("R3 out_valid", out_valid, 1);
        check("R3 second copy data", out_data, 16'hD00D);
        check("R7 no event on clean copy", err_event, 0);
        idle(1);
        check("R3 fix_count", fix_count, 1);
    endtask

    task automatic t_both_bad;
        send(16'hEEEE, 1, 0);
        send(16'hFFFF, 1, 0);
        check("R4 no output", out_valid, 0);
        idle(1);
        check("R4 lost_count", lost_count, 1);
        check("R4 fix_count unchanged", fix_count, 1);
    endtask

    task automatic t_frame;
        // expected bit is now 1; a first copy with 0 is a sequence error
        send(16'h1111, 0, 0);
        check("R5 frame on first copy", frame_count, 1);
        send(16'h2222, 0, 1);
        check("R5 mismatched second copy no output", out_valid, 0);
        check("R5 frame on pair mismatch", frame_count, 2);
        send(16'h3333, 0, 1);
        check("R5 resynced pair output", out_valid, 1);
        check("R5 resynced data", out_data, 16'h2222);
        check("R5 frame stable", frame_count, 2);
        check("R7 frame error raises no event", err_event, 0);
    endtask

    task automatic t_pass;
        dual_en = 1'b0; idle(1);
        send(16'h4444, 0, 1);
        check("R6 pass good valid", out_valid, 1);
        check("R6 pass good data", out_data, 16'h4444);
        send(16'h5555, 1, 0);
        check("R6 pass errored dropped", out_valid, 0);
        idle(1);
        check("R6 lost_count", lost_count, 2);
    endtask

    task automatic t_mode_off;
        dual_en = 1'b1; idle(1);
        send(16'h6666, 0, 0);
        dual_en = 1'b0; idle(1);
        dual_en = 1'b1; idle(1);
        send(16'h7777, 0, 0);
        check("R10 held copy discarded", out_valid, 0);
        check("R10 expected bit back to 0", frame_count, 2);
        send(16'h8888, 0, 0);
        check("R10 new pair output", out_valid, 1);
        check("R10 new pair data", out_data, 16'h7777);
    endtask

    task automatic t_irq_off;
        irq_arm = 1'b0;
        send(16'h9999, 1, 1);
        check("R7 disarmed no event", err_event, 0);
        send(16'hAAAA, 0, 1);
        check("R3 disarmed recovery data", out_data, 16'hAAAA);
        // first good, second bad also counts as one bad copy
        send(16'hBBBB, 0, 0);
        send(16'hCCCC, 1, 0);
        check("R2 second errored copy ignored", out_data, 16'hBBBB);
        idle(1);
        check("R3 fix_count", fix_count, 3);
        irq_arm = 1'b1;
    endtask

    task automatic t_sat;
        dual_en = 1'b0; idle(1);
        for (int i = 0; i < 20; i++) send(DW'(i), 1, 0);
        idle(1);
        check("R8 lost_count saturates", lost_count, 15);
        send(16'h1234, 0, 0);
        check("R8 pass still works", out_data, 16'h1234);
        check("R8 still saturated", lost_count, 15);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_good();
        t_first_bad();
        t_both_bad();
        t_frame();
        t_pass();
        t_mode_off();
        t_irq_off();
        t_sat();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule